// File: doc/BRIEF.md
# Indirect-Paged Processor Access Port

This block is the processor-facing port of a time-slot switch. To a host processor it looks like a small asynchronous memory peripheral. It has a 6-bit address, an 8-bit data bus, an active-low select, an active-high strobe, a read/write line and an acknowledge that is pulled low when the transfer is finished. The lower half of the address space reaches a single paging register. The upper half reaches 32 channel locations. The paging register chooses the memory and the stream behind those 32 locations.

The host signals arrive with no timing relation to the switch's bit clock. The port resamples the combined select-and-strobe with a flop chain. Writes to the paging register finish within a few bit-clock cycles. Memory accesses wait for a fixed access slot that recurs once per channel time. Each one then issues a single-cycle strobe to the external data memory or to the low or high connection memory. Reads take their data one cycle after that strobe.

The tri-state data bus is split into a data-in bus, a data-out bus and an output enable. The open-drain acknowledge is a "pull" output.

Top module: `indirect_cpu_port`

## Requirements
- R1: When address bit 5 is 0, the access goes to the paging register, whatever address bits 4-0 hold. Such an access never issues a memory strobe.
- R2: The paging register resets to 0. A read returns the last value written, with bit 5 forced to 0.
- R3: When address bit 5 is 1, the memory address on `mem_addr` is {paging bits 2-0 (stream), address bits 4-0 (channel)}. The paging register cannot change while an access is in progress.
- R4: Paging bits 4-3 select the memory, and `mem_sel` carries the same code: 01 is the data memory, 10 the low connection memory and 11 the high connection memory. Writes to the data memory issue no write strobe. Code 00 issues no strobe, and a read under code 00 returns 0.
- R5: When paging bit 7 is 1, reads come from the data memory and writes go to the low connection memory, whatever bits 4-3 hold.
- R6: A read of the high connection memory returns its 3 stored bits in bits 2-0, with bits 7-3 as 0.
- R7: Output `msg_all` always equals paging bit 6.
- R8: Every memory strobe (`mem_re` or `mem_we`) falls in the cycle where the slot phase equals SLOT_PHASE. The slot phase counts 0 to SLOT_PERIOD-1 and restarts at 0 after a `frame_sync` pulse. At most one strobe is issued per access, and `mem_re` and `mem_we` are never both high.
- R9: An access to the paging register is acknowledged within 3 bit-clock cycles after the strobe is applied.
- R10: The acknowledge stays asserted while both select and strobe remain active. It is released within 3 cycles after either one is removed. `bus_doe` is high only while a read is being acknowledged.
- R11: After reset, `ack_pull`, `bus_doe`, `mem_re`, `mem_we` and `msg_all` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the switch |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse that restarts the slot phase |
| bus_cs_n | input | 1 | Host select, active low |
| bus_ds | input | 1 | Host data strobe, active high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Host address |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Read data to host |
| bus_doe | output | 1 | Enable for the host data drivers |
| ack_pull | output | 1 | 1 pulls the open-drain acknowledge low |
| mem_addr | output | 8 | {stream, channel} memory address |
| mem_sel | output | 2 | Memory code (01 data, 10 conn low, 11 conn high) |
| mem_re | output | 1 | One-cycle read strobe |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| dm_rdata | input | 8 | Data memory read data, valid the cycle after `mem_re` |
| cml_rdata | input | 8 | Low connection memory read data, same timing |
| cmh_rdata | input | 3 | High connection memory read data, same timing |
| msg_all | output | 1 | Global message mode flag |

## Verification
The assertions assume that the host keeps address, read/write and write data stable from before it raises the strobe until the acknowledge is released. They also assume that it raises the strobe only after the previous acknowledge has been released. The block samples those buses directly, with no synchroniser, at the cycle in which it detects the strobe. The bench applies every bus change at the falling clock edge and holds all the fields for the whole handshake. It waits for the acknowledge to be released before starting the next transfer. The memory model in the bench answers one cycle after each read strobe, as the block expects.

// File: rtl/icp_pkg.sv
package icp_pkg;

  localparam int CR_W      = 8;
  localparam int SPLIT_BIT = 7;
  localparam int MSG_BIT   = 6;
  localparam int RSV_BIT   = 5;
  localparam int SEL_HI    = 4;
  localparam int SEL_LO    = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DM   = 2'b01,
    SEL_CML  = 2'b10,
    SEL_CMH  = 2'b11
  } mem_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_CAPT = 2'b10,
    ST_ACK  = 2'b11
  } port_state_e;

endpackage

// File: rtl/icp_sync.sv
module icp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/icp_slot.sv
module icp_slot #(
  parameter int SLOT_PERIOD = 16,
  parameter int SLOT_PHASE  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  output logic grant
);

  localparam int CW = (SLOT_PERIOD > 1) ? $clog2(SLOT_PERIOD) : 1;
  localparam logic [CW-1:0] LAST  = CW'(SLOT_PERIOD - 1);
  localparam logic [CW-1:0] PHASE = CW'(SLOT_PHASE);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (frame_sync)         cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign grant = (cnt_q == PHASE);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/icp_seq.sv
module icp_seq
  import icp_pkg::*;
#(
  parameter int CHAN_W  = 5,
  parameter int STRM_W  = 3,
  parameter int CMH_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_s,
  input  logic                       grant,
  input  logic [CHAN_W:0]            bus_addr,
  input  logic                       bus_rw,
  input  logic [CR_W-1:0]            bus_din,
  input  logic [CR_W-1:0]            dm_rdata,
  input  logic [CR_W-1:0]            cml_rdata,
  input  logic [CMH_W-1:0]           cmh_rdata,
  output logic [CR_W-1:0]            bus_dout,
  output logic                       bus_doe,
  output logic                       ack_pull,
  output logic [STRM_W+CHAN_W-1:0]   mem_addr,
  output logic [1:0]                 mem_sel,
  output logic                       mem_re,
  output logic                       mem_we,
  output logic [CR_W-1:0]            mem_wdata,
  output logic                       msg_all
);

  localparam logic [CR_W-1:0] RSV_MASK = ~(CR_W'(1) << RSV_BIT);

  port_state_e       st_q, st_d;
  logic [CR_W-1:0]   cr_q, cr_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              rd_q, rd_d;
  mem_sel_e          sel_q, sel_d;
  logic [CR_W-1:0]   rdat_q, rdat_d;
  logic [CR_W-1:0]   wdat_q, wdat_d;
  logic              prev_q;
  logic              req_rise;
  logic              page_hit;
  logic              sel_valid_rd;
  logic              sel_valid_wr;
  logic [CR_W-1:0]   mem_word;
  mem_sel_e          eff_sel;

  assign req_rise = req_s & ~prev_q;
  assign page_hit = bus_addr[CHAN_W];

  always_comb begin
    if (cr_q[SPLIT_BIT]) eff_sel = bus_rw ? SEL_DM : SEL_CML;
    else                 eff_sel = mem_sel_e'(cr_q[SEL_HI:SEL_LO]);
  end

  assign sel_valid_rd = (sel_q != SEL_NONE);
  assign sel_valid_wr = (sel_q == SEL_CML) || (sel_q == SEL_CMH);

  always_comb begin
    unique case (sel_q)
      SEL_DM:  mem_word = dm_rdata;
      SEL_CML: mem_word = cml_rdata;
      SEL_CMH: mem_word = {{(CR_W-CMH_W){1'b0}}, cmh_rdata};
      default: mem_word = '0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    cr_d   = cr_q;
    chan_d = chan_q;
    rd_d   = rd_q;
    sel_d  = sel_q;
    rdat_d = rdat_q;
    wdat_d = wdat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_rise) begin
          chan_d = bus_addr[CHAN_W-1:0];
          rd_d   = bus_rw;
          wdat_d = bus_din;
          if (!page_hit) begin
            if (bus_rw) rdat_d = cr_q;
            else        cr_d   = bus_din & RSV_MASK;
            st_d = ST_ACK;
          end else begin
            sel_d = eff_sel;
            st_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (grant) st_d = rd_q ? ST_CAPT : ST_ACK;
      end
      ST_CAPT: begin
        rdat_d = mem_word;
        st_d   = ST_ACK;
      end
      default: begin
        if (!req_s) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cr_q   <= '0;
      chan_q <= '0;
      rd_q   <= 1'b0;
      sel_q  <= SEL_NONE;
      rdat_q <= '0;
      wdat_q <= '0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cr_q   <= cr_d;
      chan_q <= chan_d;
      rd_q   <= rd_d;
      sel_q  <= sel_d;
      rdat_q <= rdat_d;
      wdat_q <= wdat_d;
      prev_q <= req_s;
    end
  end

  assign mem_re    = (st_q == ST_WAIT) && grant && rd_q && sel_valid_rd;
  assign mem_we    = (st_q == ST_WAIT) && grant && !rd_q && sel_valid_wr;
  assign mem_addr  = {cr_q[STRM_W-1:0], chan_q};
  assign mem_sel   = sel_q;
  assign mem_wdata = wdat_q;
  assign ack_pull  = (st_q == ST_ACK);
  assign bus_doe   = ack_pull && rd_q;
  assign bus_dout  = rdat_q;
  assign msg_all   = cr_q[MSG_BIT];

  AST_STROBE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> grant); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we)); // R8

  AST_NO_DM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_sel != SEL_DM) && (mem_sel != SEL_NONE)); // R4

  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(cr_q)); // R3

  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pull && req_s) |=> ack_pull); // R10

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pull && !req_s) |=> !ack_pull); // R10

  AST_OE_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> ack_pull); // R10

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !(mem_re || mem_we)); // R1

endmodule

// File: rtl/indirect_cpu_port.sv
module indirect_cpu_port
  import icp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_PERIOD = 16,
  parameter int SLOT_PHASE  = 3,
  parameter int CHAN_W      = 5,
  parameter int STRM_W      = 3,
  parameter int CMH_W       = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  input  logic                     bus_cs_n,
  input  logic                     bus_ds,
  input  logic                     bus_rw,
  input  logic [CHAN_W:0]          bus_addr,
  input  logic [7:0]               bus_din,
  output logic [7:0]               bus_dout,
  output logic                     bus_doe,
  output logic                     ack_pull,
  output logic [STRM_W+CHAN_W-1:0] mem_addr,
  output logic [1:0]               mem_sel,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               dm_rdata,
  input  logic [7:0]               cml_rdata,
  input  logic [CMH_W-1:0]         cmh_rdata,
  output logic                     msg_all
);

  logic req_raw;
  logic req_s;
  logic grant;

  assign req_raw = ~bus_cs_n & bus_ds;

  icp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (req_raw),
    .sync_out (req_s)
  );

  icp_slot #(.SLOT_PERIOD(SLOT_PERIOD), .SLOT_PHASE(SLOT_PHASE)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .grant      (grant)
  );

  icp_seq #(.CHAN_W(CHAN_W), .STRM_W(STRM_W), .CMH_W(CMH_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_s),
    .grant     (grant),
    .bus_addr  (bus_addr),
    .bus_rw    (bus_rw),
    .bus_din   (bus_din),
    .dm_rdata  (dm_rdata),
    .cml_rdata (cml_rdata),
    .cmh_rdata (cmh_rdata),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .ack_pull  (ack_pull),
    .mem_addr  (mem_addr),
    .mem_sel   (mem_sel),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .msg_all   (msg_all)
  );

  AST_MSG_FOLLOWS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_pull && $past(!ack_pull)) |-> $stable(msg_all)); // R7

endmodule

// File: tb/indirect_cpu_port_tb.sv
module indirect_cpu_port_tb;

  localparam int SLOT_PERIOD = 16;
  localparam int SLOT_PHASE  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic       bus_cs_n = 1'b1;
  logic       bus_ds = 1'b0;
  logic       bus_rw = 1'b1;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_doe, ack_pull;
  logic [7:0] mem_addr;
  logic [1:0] mem_sel;
  logic       mem_re, mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] dm_rdata = '0;
  logic [7:0] cml_rdata = '0;
  logic [2:0] cmh_rdata = '0;
  logic       msg_all;

  always #10 clk = ~clk;

  indirect_cpu_port #(.SLOT_PERIOD(SLOT_PERIOD), .SLOT_PHASE(SLOT_PHASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .bus_cs_n(bus_cs_n), .bus_ds(bus_ds), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .ack_pull(ack_pull), .mem_addr(mem_addr),
    .mem_sel(mem_sel), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .dm_rdata(dm_rdata), .cml_rdata(cml_rdata),
    .cmh_rdata(cmh_rdata), .msg_all(msg_all)
  );

  int checks = 0;
  int fails  = 0;

  // Memory model contents
  logic [7:0] dm  [256];
  logic [7:0] cml [256];
  logic [7:0] cmh [256];

  function automatic logic [7:0] dm_init(input int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [7:0] cml_init(input int i);
    return 8'(i ^ 8'hC3);
  endfunction
  function automatic logic [7:0] cmh_init(input int i);
    return 8'(8'hF8 | (i * 5));
  endfunction

  // Independent slot-phase model and strobe monitors
  int bcnt = 0;
  int nstrobe = 0;
  int nwrite = 0;
  int slot_bad = 0;
  int both_bad = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= 0;
    end else begin
      if (mem_re || mem_we) begin
        nstrobe <= nstrobe + 1;
        if (bcnt != SLOT_PHASE) slot_bad <= slot_bad + 1;
      end
      if (mem_re && mem_we) both_bad <= both_bad + 1;
      if (mem_re) begin
        dm_rdata  <= dm[mem_addr];
        cml_rdata <= cml[mem_addr];
        cmh_rdata <= cmh[mem_addr][2:0];
      end
      if (mem_we) begin
        nwrite <= nwrite + 1;
        if (mem_sel == 2'b10) cml[mem_addr] <= mem_wdata;
        if (mem_sel == 2'b11) cmh[mem_addr] <= mem_wdata;
        if (mem_sel == 2'b01) dm[mem_addr]  <= mem_wdata;
      end
      if (frame_sync)                   bcnt <= 0;
      else if (bcnt == SLOT_PERIOD - 1) bcnt <= 0;
      else                              bcnt <= bcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int last_lat;

  task automatic bus_xfer(input logic rd, input logic [5:0] a, input logic [7:0] d,
                          output logic [7:0] q);
    int lat;
    q = '0;
    @(negedge clk);
    bus_rw = rd; bus_addr = a; bus_din = d; bus_cs_n = 1'b0; bus_ds = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack_pull && lat < 300);
    last_lat = lat;
    if (!ack_pull) chk("R9 ack timeout", 0, 1);
    chk(rd ? "R10 doe on read ack" : "R10 doe off on write ack", 32'(bus_doe), 32'(rd));
    q = bus_dout;
    bus_ds = 1'b0; bus_cs_n = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (ack_pull && lat < 10);
    chk("R10 ack release within 3", 32'(lat <= 3), 1);
    chk("R10 doe off after release", 32'(bus_doe), 0);
  endtask

  task automatic exp_rd(input logic [7:0] cr, input logic [4:0] ch, output logic [7:0] e);
    int idx;
    logic [1:0] s;
    idx = {cr[2:0], ch};
    s = cr[7] ? 2'b01 : cr[4:3];
    case (s)
      2'b01:   e = dm_init(idx);
      2'b10:   e = cml_init(idx);
      2'b11:   e = {5'b0, cmh_init(idx)[2:0]};
      default: e = 8'h00;
    endcase
  endtask

  // {page register value, channel}
  localparam logic [12:0] VEC [8] = '{
    {8'h0A, 5'd5},    // data memory, stream 2
    {8'h17, 5'd31},   // conn low, stream 7
    {8'h19, 5'd9},    // conn high, stream 1
    {8'h04, 5'd3},    // code 00
    {8'h9E, 5'd0},    // split with conn-high code
    {8'h88, 5'd17},   // split with data code, stream 0
    {8'h4B, 5'd12},   // message flag + data, stream 3
    {8'h10, 5'd0}     // conn low, stream 0, channel 0
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] q, e;
    int s0, w0;
    for (int i = 0; i < 256; i++) begin
      dm[i] = dm_init(i); cml[i] = cml_init(i); cmh[i] = cmh_init(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 ack_pull", 32'(ack_pull), 0);
    chk("R11 bus_doe", 32'(bus_doe), 0);
    chk("R11 mem strobes", 32'(mem_re | mem_we), 0);
    chk("R11 msg_all", 32'(msg_all), 0);
    bus_xfer(1'b1, 6'h00, 8'h00, q);
    chk("R2 page reg resets to 0", 32'(q), 0);

    // R8 resync of the slot phase
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;

    // R1 R2 R7 R9 page register access
    s0 = nstrobe;
    bus_xfer(1'b0, 6'h00, 8'hFF, q);
    chk("R9 page write latency <= 3", 32'(last_lat <= 3), 1);
    bus_xfer(1'b1, 6'h1F, 8'h00, q);
    chk("R9 page read latency <= 3", 32'(last_lat <= 3), 1);
    chk("R2 bit5 reads 0, R1 any low address", 32'(q), 32'h DF);
    chk("R7 msg_all set", 32'(msg_all), 1);
    chk("R1 no memory strobe on page access", 32'(nstrobe - s0), 0);
    bus_xfer(1'b0, 6'h15, 8'h12, q);
    bus_xfer(1'b1, 6'h0C, 8'h00, q);
    chk("R1 page write via address 0x15", 32'(q), 32'h12);
    chk("R7 msg_all clear", 32'(msg_all), 0);

    // Table-driven reads: R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      logic [7:0] cr;
      logic [4:0] ch;
      cr = VEC[v][12:5]; ch = VEC[v][4:0];
      bus_xfer(1'b0, 6'h00, cr, q);
      chk("R7 msg_all follows bit 6", 32'(msg_all), 32'(cr[6]));
      s0 = nstrobe;
      bus_xfer(1'b1, {1'b1, ch}, 8'h00, q);
      exp_rd(cr, ch, e);
      $display("vec %0d cr=%02h ch=%0d", v, cr, ch);
      chk("R3 R4 R5 R6 table read", 32'(q), 32'(e));
      chk("R4 strobes per read", 32'(nstrobe - s0), 32'((cr[7] || cr[4:3] != 2'b00) ? 1 : 0));
    end

    // R4 R3 conn-low write and readback
    bus_xfer(1'b0, 6'h00, 8'h15, q);
    w0 = nwrite;
    bus_xfer(1'b0, 6'h27, 8'hA5, q);
    chk("R4 conn-low write strobe", 32'(nwrite - w0), 1);
    chk("R3 conn-low stored at {5,7}", 32'(cml[5*32+7]), 32'hA5);
    bus_xfer(1'b1, 6'h27, 8'h00, q);
    chk("R4 conn-low readback", 32'(q), 32'hA5);

    // R6 conn-high write and readback
    bus_xfer(1'b0, 6'h00, 8'h1A, q);
    bus_xfer(1'b0, 6'h3F, 8'hFF, q);
    chk("R6 conn-high stored", 32'(cmh[2*32+31]), 32'hFF);
    bus_xfer(1'b1, 6'h3F, 8'h00, q);
    chk("R6 conn-high upper bits read 0", 32'(q), 32'h07);

    // R4 writes to data memory are dropped
    bus_xfer(1'b0, 6'h00, 8'h0B, q);
    w0 = nwrite;
    bus_xfer(1'b0, 6'h22, 8'h00, q);
    chk("R4 no write strobe to data memory", 32'(nwrite - w0), 0);
    bus_xfer(1'b1, 6'h22, 8'h00, q);
    chk("R4 data memory unchanged", 32'(q), 32'(dm_init(3*32+2)));

    // R4 code 00 writes dropped
    bus_xfer(1'b0, 6'h00, 8'h01, q);
    w0 = nwrite;
    bus_xfer(1'b0, 6'h21, 8'h55, q);
    chk("R4 no write strobe for code 00", 32'(nwrite - w0), 0);

    // R5 split mode write goes to conn low regardless of code
    bus_xfer(1'b0, 6'h00, 8'h9B, q);
    bus_xfer(1'b0, 6'h24, 8'h3C, q);
    chk("R5 split write to conn low", 32'(cml[3*32+4]), 32'h3C);
    chk("R5 conn high untouched", 32'(cmh[3*32+4]), 32'(cmh_init(3*32+4)));
    bus_xfer(1'b1, 6'h24, 8'h00, q);
    chk("R5 split read from data memory", 32'(q), 32'(dm_init(3*32+4)));

    // R10 acknowledge hold and release on select removal only
    @(negedge clk);
    bus_rw = 1'b1; bus_addr = 6'h00; bus_cs_n = 1'b0; bus_ds = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int held;
      held = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!ack_pull || !bus_doe) held = 0;
      end
      chk("R10 ack and doe held while active", 32'(held), 1);
    end
    bus_cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ack released after select removed", 32'(ack_pull), 0);
    bus_ds = 1'b0;
    repeat (2) @(negedge clk);

    // R8 slot placement over the whole run
    chk("R8 every strobe in slot phase", 32'(slot_bad), 0);
    chk("R8 never both strobes", 32'(both_bad), 0);
    chk("R8 strobes observed", 32'(nstrobe > 10), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule